// File: doc/BRIEF.md
# Bus-Master Disk DMA Channel Register Block

This block holds the host-visible control state of one channel of a bus-master disk DMA engine. The host reaches it through a byte-wide register port with three live offsets: 0 holds the run command, 2 holds the channel status, and 3 holds the per-drive UDMA control byte. The DMA engine feeds back a busy level, a completion pulse and a fault pulse. From these the block keeps a run bit, a read-only active bit, sticky completion and fault flags, software-owned DMA-capable bits for two drives, and a channel-disabled bit.

The UDMA control byte is decoded for the downstream timing logic. For each drive it gives a UDMA enable, a high-speed select and the number of strobe clocks. A level output reports that a transfer finished cleanly. The host ends a transfer by reading status, clearing the run bit and then writing status back with bits 1 and 2 set. Because a write of zero to the flag bits leaves them alone, the host can change the capable bits with a read-modify-write without losing a pending event.

Top module: `bmdma_chan`

## Requirements
- R1: After reset, every register reads 0x00, and `run`, `intr`, `xfer_good`, `udma_en`, `udma_fast`, `drv0_clks` and `drv1_clks` are all 0.
- R2: A write to offset 0 loads bit 0 into the run bit, and `run` shows the new value one clock after the write. Reading offset 0 returns the run bit in bit 0 and zeros in bits 7:1.
- R3: Status bit 0 (active) is read-only. One clock after any edge, it equals the run value after that edge's write, ANDed with `eng_busy` and with the inverse of `eng_done`. So it drops when run is cleared or when the engine reports completion.
- R4: Status bit 2 (interrupt, also driven on `intr`) is set one clock after an `eng_done` pulse. It stays set until the host writes offset 2 with bit 2 = 1.
- R5: Status bit 1 (fault) is set one clock after an `eng_fault` pulse. It stays set until the host writes offset 2 with bit 1 = 1.
- R6: A write to offset 2 with bit 1 or bit 2 at 0 leaves that flag unchanged. When an engine event and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R7: Status bits 5 and 6 (DMA-capable for drive 0 and drive 1) and bit 7 (channel disabled) are loaded by a write to offset 2 and read back unchanged. Status bits 3 and 4 always read 0.
- R8: `xfer_good` is 1 exactly when status bits [2:0] equal 3'b100: interrupt set, no fault, not active.
- R9: Offset 3 reads back the last byte written to it. `udma_en[u]` is bit u and `udma_fast[u]` is bit 2+u of that byte, for drive u = 0 or 1.
- R10: The 2-bit timing field of drive u sits at bits [5+2u:4+2u] of the offset 3 byte. Codes 1, 2 and 3 give 2, 3 and 4 clocks on `drv0_clks`/`drv1_clks`, and code 0 gives 0 (no timing programmed).
- R11: Offset 1 always reads 0x00, and writes to it change no register or output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| eng_busy | input | 1 | Engine is moving data |
| eng_done | input | 1 | One-cycle completion event |
| eng_fault | input | 1 | One-cycle fault event |
| run | output | 1 | Run command to the engine |
| intr | output | 1 | Interrupt flag |
| xfer_good | output | 1 | Status [2:0] equals 3'b100 |
| udma_en | output | 2 | Per-drive UDMA enable |
| udma_fast | output | 2 | Per-drive high-speed select |
| drv0_clks | output | 3 | Drive 0 strobe clock count |
| drv1_clks | output | 3 | Drive 1 strobe clock count |

## Verification
Directed sequences cover a clean transfer and the end-of-transfer clearing write. They also cover a stop issued while the engine is still busy, which shows the active bit dropping without a completion event. Two further cases tell the priorities apart: a completion pulse in the same cycle as a clearing write, and a capable-bit write with zero flag bits. These separate "set wins" and "zero has no effect" from plain overwrite behaviour. Field-crossing UDMA bytes such as 0x15, 0x4A and 0xC2 expose swapped drive fields, and every timing code is tried for both drives. A pseudo-random phase then mixes writes to all four offsets with engine events and is checked against the reference model on every clock.

// File: rtl/bmdma_chan.sv
module bmdma_chan (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       eng_busy,
  input  logic       eng_done,
  input  logic       eng_fault,
  output logic       run,
  output logic       intr,
  output logic       xfer_good,
  output logic [1:0] udma_en,
  output logic [1:0] udma_fast,
  output logic [2:0] drv0_clks,
  output logic [2:0] drv1_clks
);

  logic       run_q, act_q, irq_q, err_q, dis_q;
  logic [1:0] cap_q;
  logic [7:0] udma_q;
  logic       wr_cmd, wr_sts, wr_udma, run_nx;
  logic [7:0] status;

  assign wr_cmd  = reg_wr && (reg_addr == 2'd0);
  assign wr_sts  = reg_wr && (reg_addr == 2'd2);
  assign wr_udma = reg_wr && (reg_addr == 2'd3);
  assign run_nx  = wr_cmd ? reg_wdata[0] : run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      act_q  <= 1'b0;
      irq_q  <= 1'b0;
      err_q  <= 1'b0;
      cap_q  <= 2'b00;
      dis_q  <= 1'b0;
      udma_q <= 8'h00;
    end else begin
      run_q <= run_nx;
      act_q <= run_nx & eng_busy & ~eng_done;
      irq_q <= eng_done  | (irq_q & ~(wr_sts & reg_wdata[2]));
      err_q <= eng_fault | (err_q & ~(wr_sts & reg_wdata[1]));
      if (wr_sts) begin
        cap_q <= reg_wdata[6:5];
        dis_q <= reg_wdata[7];
      end
      if (wr_udma) udma_q <= reg_wdata;
    end
  end

  function automatic logic [2:0] clks_of(input logic [1:0] code);
    return (code == 2'd0) ? 3'd0 : {1'b0, code} + 3'd1;
  endfunction

  assign status    = {dis_q, cap_q, 2'b00, irq_q, err_q, act_q};
  assign run       = run_q;
  assign intr      = irq_q;
  assign xfer_good = (status[2:0] == 3'b100);
  assign udma_en   = udma_q[1:0];
  assign udma_fast = udma_q[3:2];
  assign drv0_clks = clks_of(udma_q[5:4]);
  assign drv1_clks = clks_of(udma_q[7:6]);

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {7'd0, run_q};
      2'd2:    reg_rdata = status;
      2'd3:    reg_rdata = udma_q;
      default: reg_rdata = 8'h00;
    endcase
  end

endmodule

module bmdma_chan_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       eng_done,
  input logic       eng_fault,
  input logic       run,
  input logic       intr,
  input logic       xfer_good,
  input logic       act,
  input logic       err
);

  a_r2_run_load: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0) |=> (run == $past(reg_wdata[0])));

  a_r3_active_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> run);

  a_r3_done_drops_active: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> !act);

  a_r4_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> intr);

  a_r6_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (intr && !(reg_wr && reg_addr == 2'd2 && reg_wdata[2])) |=> intr);

  a_r5_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    eng_fault |=> err);

  a_r6_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !(reg_wr && reg_addr == 2'd2 && reg_wdata[1])) |=> err);

  a_r8_good_flags: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_good |-> (intr && !err && !act));

endmodule

bind bmdma_chan bmdma_chan_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .eng_done(eng_done), .eng_fault(eng_fault),
  .run(run), .intr(intr), .xfer_good(xfer_good), .act(act_q), .err(err_q)
);

// File: tb/test_bmdma_chan.sv
`timescale 1ns/1ps
module test_bmdma_chan;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic       eng_busy = 1'b0, eng_done = 1'b0, eng_fault = 1'b0;
  logic [7:0] reg_rdata;
  logic       run, intr, xfer_good;
  logic [1:0] udma_en, udma_fast;
  logic [2:0] drv0_clks, drv1_clks;

  bmdma_chan i_bmdma_chan (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  bit m_run = 0, m_act = 0, m_irq = 0, m_err = 0, m_dis = 0;
  bit [1:0] m_cap = 0;
  bit [7:0] m_udma = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_act = 0; m_irq = 0; m_err = 0; m_dis = 0; m_cap = 0; m_udma = 0;
    end else begin
      bit nrun;
      nrun = (reg_wr && reg_addr == 0) ? reg_wdata[0] : m_run;
      m_act = nrun && eng_busy && !eng_done;
      m_irq = eng_done || (m_irq && !(reg_wr && reg_addr == 2 && reg_wdata[2]));
      m_err = eng_fault || (m_err && !(reg_wr && reg_addr == 2 && reg_wdata[1]));
      if (reg_wr && reg_addr == 2) begin m_cap = reg_wdata[6:5]; m_dis = reg_wdata[7]; end
      if (reg_wr && reg_addr == 3) m_udma = reg_wdata;
      m_run = nrun;
    end
  end

  function automatic int clk_exp(input int code);
    return (code == 0) ? 0 : code + 1;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int exp_rd;
      case (reg_addr)
        0: exp_rd = {7'd0, m_run};
        2: exp_rd = {m_dis, m_cap, 2'b00, m_irq, m_err, m_act};
        3: exp_rd = m_udma;
        default: exp_rd = 0;
      endcase
      chk(run == m_run, "R2 run", run, m_run);
      chk(intr == m_irq, "R4 intr", intr, m_irq);
      chk(xfer_good == (m_irq && !m_err && !m_act), "R8 xfer_good", xfer_good, m_irq && !m_err && !m_act);
      chk(udma_en == m_udma[1:0] && udma_fast == m_udma[3:2], "R9 udma bits",
          {udma_fast, udma_en}, m_udma[3:0]);
      chk(drv0_clks == clk_exp(m_udma[5:4]) && drv1_clks == clk_exp(m_udma[7:6]), "R10 clocks",
          {drv1_clks, drv0_clks}, {clk_exp(m_udma[7:6]), clk_exp(m_udma[5:4])});
      chk(reg_rdata == exp_rd[7:0],
          reg_addr == 2 ? "R3/R5/R7 status read" : (reg_addr == 1 ? "R11 offset 1 read" : "R2/R9 read"),
          reg_rdata, exp_rd);
    end
  end

  task automatic step(input bit wr, input int a, input int d, input bit busy, input bit dn, input bit flt);
    reg_wr = wr; reg_addr = a[1:0]; reg_wdata = d[7:0];
    eng_busy = busy; eng_done = dn; eng_fault = flt;
    @(posedge clk); #1;
    reg_wr = 0; eng_done = 0; eng_fault = 0;
  endtask

  task automatic look(input int a);
    reg_addr = a[1:0];
    @(negedge clk); #0.5;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    look(2);
    chk(reg_rdata == 8'h00 && !run && !intr && !xfer_good, "R1 reset state", reg_rdata, 0);
    look(3);
    chk(reg_rdata == 8'h00 && drv0_clks == 0 && drv1_clks == 0, "R1 reset udma", reg_rdata, 0);

    step(1, 0, 8'hFF, 1, 0, 0);
    step(0, 2, 0, 1, 0, 0);
    look(2);
    chk(reg_rdata[0] == 1'b1, "R3 active while busy", reg_rdata, 1);
    step(0, 2, 0, 0, 1, 0);
    look(2);
    chk(reg_rdata[2:0] == 3'b100 && xfer_good, "R8 clean end", reg_rdata, 4);
    step(1, 0, 0, 0, 0, 0);
    step(1, 2, 8'h60, 0, 0, 0);
    look(2);
    chk(reg_rdata == 8'h64, "R6 zero write keeps irq", reg_rdata, 8'h64);
    step(1, 2, 8'h66, 0, 1, 0);
    look(2);
    chk(reg_rdata[2] == 1'b1, "R6 set wins over clear", reg_rdata, 8'h64);
    step(1, 2, 8'h06, 0, 0, 0);
    look(2);
    chk(reg_rdata == 8'h00, "R4 W1C clears irq", reg_rdata, 0);
    step(0, 2, 0, 0, 0, 1);
    look(2);
    chk(reg_rdata == 8'h02 && !xfer_good, "R5 fault sticky", reg_rdata, 2);
    step(1, 2, 8'h82, 0, 0, 0);
    look(2);
    chk(reg_rdata == 8'h80, "R7 disabled bit / R5 clear", reg_rdata, 8'h80);
    step(1, 0, 1, 1, 0, 0);
    step(1, 0, 0, 1, 0, 0);
    look(2);
    chk(reg_rdata[0] == 1'b0, "R3 stop while busy", reg_rdata, 0);
    step(1, 1, 8'hFF, 0, 0, 0);
    look(1);
    chk(reg_rdata == 8'h00, "R11 offset 1 ignored", reg_rdata, 0);
    foreach (m_udma[i]) begin end
    for (int k = 0; k < 4; k++) begin
      int v;
      v = (k == 0) ? 8'h15 : (k == 1) ? 8'h4A : (k == 2) ? 8'hC2 : 8'hA7;
      step(1, 3, v, 0, 0, 0);
      look(3);
      chk(reg_rdata == v[7:0], "R9 udma readback", reg_rdata, v);
    end

    begin
      bit [15:0] lfsr = 16'hACE1;
      for (int n = 0; n < 3000; n++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        step(lfsr[0] & lfsr[5], lfsr[2:1], {lfsr[9:6], lfsr[13:10]}, lfsr[3] | lfsr[11],
             lfsr[4] & lfsr[8] & lfsr[12], lfsr[14] & lfsr[7] & lfsr[9]);
      end
    end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule